// File: doc/BRIEF.md
# Extended Hamming (8,4) Error Correcting Codec

This block protects a 4-bit value with a single-error-correcting, double-error-detecting code. The encoder side turns a data nibble into an 8-bit stored word: three check bits, each an even parity over a different group of three data bits, plus one extra bit giving even parity over the whole word. The decoder side takes a word that may have been corrupted in storage or in transit. It recomputes the three check equations to form a syndrome and checks the parity of the whole word. From these two results it recovers the nibble and reports what it found.

The data and check fields are separate, so after correction the data bits are read straight from their own positions. The syndrome does not give a bit position in binary. Instead, each nonzero syndrome value is matched to one bit through a fixed column table. Both paths are purely combinational and the two paths are independent of each other. A design can encode on write and decode on read in the same cycle as the access.

Word layout (bit 7 down to bit 0): overall parity, d3, d2, d1, d0, p2, p1, p0.

Top module: `ecc84_codec`

## Requirements
- R1: The check bits are p2 = d3^d2^d1, p1 = d3^d1^d0 and p0 = d2^d1^d0. The encoded word carries d3..d0 in bits 6..3 and p2..p0 in bits 2..0.
- R2: Encoded bit 7 makes the XOR of all eight bits zero.
- R3: A word that is a valid codeword decodes to its data bits, with both flags low.
- R4: A word with one flipped bit among bits 0..6 decodes to the original data, with the single flag high and the double flag low. The syndrome {s2,s1,s0} selects the bit: 001 selects bit 0, 010 bit 1, 100 bit 2, 011 bit 3, 111 bit 4, 101 bit 5 and 110 bit 6.
- R5: A word with only bit 7 flipped decodes to unchanged data, with the single flag high and the double flag low.
- R6: A word with exactly two flipped bits raises the double flag and leaves the single flag low. The data output then equals received bits 6..3, with no correction applied.
- R7: The single flag and the double flag are never high together, and the decoder changes at most one data bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| enc_data_i | input | 4 | Nibble to encode |
| enc_word_o | output | 8 | Encoded word, layout above |
| dec_word_i | input | 8 | Received word to check and correct |
| dec_data_o | output | 4 | Recovered nibble |
| dec_single_o | output | 1 | One bit error seen (corrected, or in bit 7) |
| dec_double_o | output | 1 | Two bit errors seen, data left as received |

## Verification
The bench flips every one of the eight word positions for every data value. A wrong entry in the syndrome column table would flip the wrong data bit and return a bad nibble. It also covers the case where only the overall bit is wrong. A design that treats this case as a data error, or as a clean word, would report the wrong flag. Every pair of flipped bits is applied, including pairs that contain bit 7. A decoder that tries to correct such a word would change a data bit and raise the single flag instead of the double flag.

// File: rtl/ecc84_pkg.sv
// Package: ecc84_pkg
// Holds the code geometry and the parity-check rows shared by the encoder
// and decoder. Each row covers word bits 6..0 in the order d3 d2 d1 d0 p2 p1 p0.
// Assumes a fixed (8,4) code; only this one layout is supported.
package ecc84_pkg;
    localparam int DATA_W = 4;
    localparam int PAR_W  = 3;
    localparam int BASE_W = DATA_W + PAR_W;
    localparam int WORD_W = BASE_W + 1;

    // Row 2 checks d3 d2 d1 p2, row 1 checks d3 d1 d0 p1, row 0 checks d2 d1 d0 p0
    localparam logic [PAR_W-1:0][BASE_W-1:0] H_ROWS = {
        7'b1110100,
        7'b1011010,
        7'b0111001
    };

    // Column j of the check matrix: the syndrome a flip of bit j produces
    function automatic logic [PAR_W-1:0] h_col(input int j);
        logic [PAR_W-1:0] c;
        for (int i = 0; i < PAR_W; i++) begin
            c[i] = H_ROWS[i][j];
        end
        return c;
    endfunction
endpackage

// File: rtl/ecc84_encoder.sv
// Module: ecc84_encoder
// Forms the three check bits from the data nibble, then adds the overall
// even-parity bit. Purely combinational; the data rows come from the check
// matrix, so the encoder and the syndrome unit cannot disagree.
module ecc84_encoder
    import ecc84_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    output logic [WORD_W-1:0] word_o
);
    logic [PAR_W-1:0] par;

    // One XOR tree per check bit over the data bits its row covers
    for (genvar i = 0; i < PAR_W; i++) begin : g_par
        assign par[i] = ^(data_i & H_ROWS[i][BASE_W-1:PAR_W]);
    end

    // Assemble the word: overall parity, data field, check field
    assign word_o = {^{data_i, par}, data_i, par};
endmodule

// File: rtl/ecc84_syndrome.sv
// Module: ecc84_syndrome
// Recomputes each check equation over the received bits 6..0 to form the
// syndrome. Also reports odd parity across all eight bits. Combinational.
module ecc84_syndrome
    import ecc84_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output logic [PAR_W-1:0]  syn_o,
    output logic              mismatch_o
);
    // One XOR tree per syndrome bit
    for (genvar i = 0; i < PAR_W; i++) begin : g_syn
        assign syn_o[i] = ^(word_i[BASE_W-1:0] & H_ROWS[i]);
    end

    // Overall parity check across every bit including the extra one
    assign mismatch_o = ^word_i;
endmodule

// File: rtl/ecc84_corrector.sv
// Module: ecc84_corrector
// Classifies the error from the syndrome and the overall-parity result, then
// flips the indicated data bit when exactly one error is present. Check-bit
// errors need no data change, so only data columns get flip logic.
module ecc84_corrector
    import ecc84_pkg::*;
(
    input  logic [DATA_W-1:0] data_raw_i,
    input  logic [PAR_W-1:0]  syn_i,
    input  logic              mismatch_i,
    output logic [DATA_W-1:0] data_o,
    output logic              single_o,
    output logic              double_o
);
    logic              syn_nz;
    logic              fix_en;
    logic [DATA_W-1:0] flip;

    // Error class: odd parity means one error, even parity with a nonzero syndrome means two
    assign syn_nz   = |syn_i;
    assign fix_en   = syn_nz & mismatch_i;
    assign single_o = mismatch_i;
    assign double_o = syn_nz & ~mismatch_i;

    // Match the syndrome against each data column to build the flip mask
    for (genvar j = 0; j < DATA_W; j++) begin : g_flip
        localparam logic [PAR_W-1:0] COL = h_col(j + PAR_W);
        assign flip[j] = fix_en && (syn_i == COL);
    end

    // Apply the flip mask to the raw data field
    assign data_o = data_raw_i ^ flip;

    // Checks on the decision outputs
    always_comb begin
        AST_FLIP_ONEHOT: assert ($onehot0(flip)) else $error("flip mask not one-hot"); // R4
        AST_FLAGS_EXCL: assert (!(single_o && double_o)) else $error("both flags high"); // R7
        AST_DOUBLE_RAW: assert (!double_o || (data_o == data_raw_i)) else $error("data altered on double error"); // R6
        AST_CLEAN_PASS: assert (single_o || double_o || (data_o == data_raw_i)) else $error("clean word altered"); // R3
        AST_ONE_BIT_FIX: assert ($countones(data_o ^ data_raw_i) <= 1) else $error("more than one bit changed"); // R7
    end
endmodule

// File: rtl/ecc84_codec.sv
// Module: ecc84_codec
// Top of the (8,4) single-correct double-detect codec. The encode path and the
// decode path are independent and both combinational. Word layout, MSB first:
// overall parity, d3 d2 d1 d0, p2 p1 p0.
module ecc84_codec
    import ecc84_pkg::*;
(
    input  logic [DATA_W-1:0] enc_data_i,
    output logic [WORD_W-1:0] enc_word_o,
    input  logic [WORD_W-1:0] dec_word_i,
    output logic [DATA_W-1:0] dec_data_o,
    output logic              dec_single_o,
    output logic              dec_double_o
);
    logic [PAR_W-1:0] syn;
    logic             mismatch;

    // Encode path
    ecc84_encoder u_enc (
        .data_i (enc_data_i),
        .word_o (enc_word_o)
    );

    // Decode path: syndrome and parity check
    ecc84_syndrome u_syn (
        .word_i     (dec_word_i),
        .syn_o      (syn),
        .mismatch_o (mismatch)
    );

    // Decode path: classification and correction
    ecc84_corrector u_cor (
        .data_raw_i (dec_word_i[BASE_W-1:PAR_W]),
        .syn_i      (syn),
        .mismatch_i (mismatch),
        .data_o     (dec_data_o),
        .single_o   (dec_single_o),
        .double_o   (dec_double_o)
    );

    // A valid codeword never raises a flag
    always_comb begin
        AST_SYN_ZERO_CLEAN: assert ((syn != '0) || mismatch || (!dec_single_o && !dec_double_o)) else $error("flag on clean word"); // R3
    end
endmodule

// File: tb/ecc84_codec_test.sv
module ecc84_codec_test;
    logic       clk = 1'b0;
    logic [3:0] enc_data;
    logic [7:0] enc_word;
    logic [7:0] dec_word;
    logic [3:0] dec_data;
    logic       dec_single;
    logic       dec_double;
    int         total = 0;
    int         bad = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    ecc84_codec uut (
        .enc_data_i   (enc_data),
        .enc_word_o   (enc_word),
        .dec_word_i   (dec_word),
        .dec_data_o   (dec_data),
        .dec_single_o (dec_single),
        .dec_double_o (dec_double)
    );

    // Reference encoder written from the R1 and R2 equations
    function automatic logic [7:0] ref_enc(input logic [3:0] d);
        logic p2, p1, p0;
        p2 = d[3] ^ d[2] ^ d[1];
        p1 = d[3] ^ d[1] ^ d[0];
        p0 = d[2] ^ d[1] ^ d[0];
        return {d[3]^d[2]^d[1]^d[0]^p2^p1^p0, d, p2, p1, p0};
    endfunction

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // Drive a received word away from the clock edge, then check all decode outputs
    task automatic decode(input string req, input logic [7:0] w, input logic [3:0] xd,
                          input logic xs, input logic xdb);
        @(negedge clk);
        dec_word = w;
        #2;
        chk(req, {4'h0, dec_data}, {4'h0, xd});
        chk(req, {6'h0, dec_single, dec_double}, {6'h0, xs, xdb});
    endtask

    // Vectors: data, error mask, expected data, single flag, double flag
    localparam int NV = 10;
    localparam logic [17:0] VEC [NV] = '{
        {4'hA, 8'h00, 4'hA, 1'b0, 1'b0},
        {4'h5, 8'h01, 4'h5, 1'b1, 1'b0},
        {4'h3, 8'h08, 4'h3, 1'b1, 1'b0},
        {4'hF, 8'h40, 4'hF, 1'b1, 1'b0},
        {4'h0, 8'h80, 4'h0, 1'b1, 1'b0},
        {4'h9, 8'h03, 4'h9, 1'b0, 1'b1},
        {4'h6, 8'h18, 4'h5, 1'b0, 1'b1},
        {4'hC, 8'h84, 4'hC, 1'b0, 1'b1},
        {4'h1, 8'h60, 4'hD, 1'b0, 1'b1},
        {4'h7, 8'h00, 4'h7, 1'b0, 1'b0}
    };

    initial begin
        #4_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        enc_data = 4'h0;
        dec_word = 8'h00;
        repeat (2) @(posedge clk);
        // Initial state: all-zero word is clean (R3)
        #2;
        chk("R3 initial", {dec_single, dec_double, 2'b0, dec_data}, 8'h00);
        chk("R1 initial enc", enc_word, 8'h00);

        // Table walk (R3 R4 R5 R6)
        for (int v = 0; v < NV; v++) begin
            decode("R3/R4/R5/R6 table", ref_enc(VEC[v][17:14]) ^ VEC[v][13:6],
                   VEC[v][5:2], VEC[v][1], VEC[v][0]);
        end

        // Encoder over every nibble (R1 R2)
        for (int d = 0; d < 16; d++) begin
            @(negedge clk);
            enc_data = 4'(d);
            #2;
            chk("R1 encode", {1'b0, enc_word[6:0]}, {1'b0, ref_enc(4'(d))[6:0]});
            chk("R2 overall parity", {7'h0, ^enc_word}, 8'h00);
        end

        // Every nibble, clean and with every single flip (R3 R4 R5)
        for (int d = 0; d < 16; d++) begin
            decode("R3 clean", ref_enc(4'(d)), 4'(d), 1'b0, 1'b0);
            for (int b = 0; b < 7; b++) begin
                decode("R4 single fix", ref_enc(4'(d)) ^ (8'h01 << b), 4'(d), 1'b1, 1'b0);
            end
            decode("R5 overall bit only", ref_enc(4'(d)) ^ 8'h80, 4'(d), 1'b1, 1'b0);
        end

        // Every pair of flips on two data values (R6 R7)
        for (int d = 0; d < 16; d += 9) begin
            for (int a = 0; a < 8; a++) begin
                for (int b = a + 1; b < 8; b++) begin
                    logic [7:0] m;
                    m = (8'h01 << a) | (8'h01 << b);
                    decode("R6/R7 double", ref_enc(4'(d)) ^ m, 4'(d) ^ m[6:3], 1'b0, 1'b1);
                end
            end
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule